// File: doc/BRIEF.md
# Fuse Bit Program Controller with Row Locking

This block takes one-time-programmable fuse program requests. Each request carries a packed 17-bit address that names a page, a row and a column. The block decides whether that single fuse bit may be burned. When the answer is yes, it sets the bit in an internal fuse array. That array is modelled as 32-bit rows and is small enough for simulation. A read port returns any whole row, so software, or a bench, can see the outcome.

The permission decision combines four inputs:
- a global program enable;
- a sticky software lock that guards a band of rows on page 0;
- a fixed table that ties groups of page-0 rows to individual lock fuses, so burning a lock fuse closes those rows for good;
- a range on page 2 that is guarded by one more lock fuse.

Every request produces a one-cycle done pulse. A refused request also produces an error pulse and sets a sticky error flag.

Top module: `fuse_prog_ctrl`

## Requirements
- R1: The request address packs the column in bits 4:0, the row in bits 12:5 and the page in bits 16:13. A granted request sets bit `column` of row `row` on page `page`. That bit shows as bit `column` of `rd_word` when `rd_page`/`rd_row` select that row.
- R2: When `pgm_en` is low, every request is refused and no fuse bit changes.
- R3: A one-cycle `soft_lock_set` pulse sets a sticky lock that only reset clears. While the lock is set, requests to page 0 rows 44 to 51 inclusive are refused. Rows 43 and 52 are not affected by it.
- R4: A page-0 request is refused when the lock fuse tied to its row is already burned. The lock fuses sit on page 0:
  - rows 8–11 → row 43 column 27;
  - rows 12–19 → row 43 column 11;
  - rows 20–27 → row 43 column 13;
  - rows 28–35 → row 43 column 15;
  - row 37 → row 43 column 28;
  - rows 64–71 → row 43 column 6;
  - rows 72–79 → row 43 column 7;
  - rows 80–87 → row 43 column 8;
  - row 4 → row 4 column 31.
- R5: A page-0 row that has no entry in the R4 table is never refused by a lock fuse.
- R6: On page 2, a position from row 129 column 0 up to row 255 column 27 is refused once page 0 row 43 column 16 is burned. Row 128, and columns 28–31 of row 255, are not locked. Pages 1 and 2 are otherwise free.
- R7: A request produces exactly one `done_pulse`, high for the single cycle after the clock edge that sampled it. A refused request raises `err_pulse` in that same cycle. No pulse appears without a request.
- R8: `err_status` is set by every refused request. It stays set until `err_clr` is sampled high or reset is applied. When a refusal and `err_clr` arrive in the same cycle, the refusal wins.
- R9: Programming a bit that is already 1 is a success and leaves it at 1. No granted request clears any bit.
- R10: A request whose page is at or above `PAGES` is refused and changes no bit.
- R11: Reset clears the whole fuse array, the sticky lock, the error flag and both pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also initialises the fuse array |
| pgm_en | input | 1 | Global program enable level |
| soft_lock_set | input | 1 | Pulse that sets the sticky row-band lock |
| err_clr | input | 1 | Clears the sticky error flag |
| req_valid | input | 1 | Program request strobe |
| req_addr | input | 17 | Packed page/row/column of the bit to burn |
| rd_page | input | 4 | Page of the row to read |
| rd_row | input | 8 | Row to read |
| rd_word | output | 32 | Contents of the selected row; 0 when out of range |
| done_pulse | output | 1 | One-cycle completion event |
| err_pulse | output | 1 | One-cycle refusal event |
| err_status | output | 1 | Sticky refusal flag |

## Verification
The bench aims at the edges of every locked range:
- rows 43 and 52 around the software band;
- rows 128 and 255 columns 27/28 around the page-2 window;
- the self-guarding row 4, whose own lock bit sits in the row it guards.

A design with an off-by-one range would burn a bit it should refuse, or refuse one it should burn. A lock fuse programmed on one cycle must block a request to its rows on the very next cycle; a design that evaluates the lock against stale array state would let that request through. The bench also sends a refusal in the same cycle as an error clear, re-programs bits that are already 1, and uses pages beyond the array. These catch a clear that wins over a set, a toggling write, and a wrapped index.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;
  localparam int PAGE_W = 4;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 5;
  localparam int WORD_W = 32;
  localparam int ADDR_W = PAGE_W + ROW_W + COL_W;

  localparam logic [ROW_W-1:0]  LOCK_ROW     = 8'd43;
  localparam logic [ROW_W-1:0]  BAND_LO      = 8'd44;
  localparam logic [ROW_W-1:0]  BAND_HI      = 8'd51;
  localparam logic [PAGE_W-1:0] WIN_PAGE     = 4'd2;
  localparam logic [COL_W-1:0]  WIN_LOCK_COL = 5'd16;
  localparam logic [ROW_W+COL_W-1:0] WIN_LO = {8'd129, 5'd0};
  localparam logic [ROW_W+COL_W-1:0] WIN_HI = {8'd255, 5'd27};

  // page in the top bits, column in the bottom bits
  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } fuse_addr_t;

  typedef struct packed {
    logic             hit;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } lock_ptr_t;

  // page-0 row to guarding fuse position
  function automatic lock_ptr_t page0_guard(input logic [ROW_W-1:0] r);
    lock_ptr_t p;
    p.hit = 1'b1;
    p.row = LOCK_ROW;
    p.col = '0;
    if (r == 8'd4) begin
      p.row = 8'd4;
      p.col = 5'd31;
    end else if (r >= 8'd8  && r <= 8'd11) p.col = 5'd27;
    else if (r >= 8'd12 && r <= 8'd19) p.col = 5'd11;
    else if (r >= 8'd20 && r <= 8'd27) p.col = 5'd13;
    else if (r >= 8'd28 && r <= 8'd35) p.col = 5'd15;
    else if (r == 8'd37)               p.col = 5'd28;
    else if (r >= 8'd64 && r <= 8'd71) p.col = 5'd6;
    else if (r >= 8'd72 && r <= 8'd79) p.col = 5'd7;
    else if (r >= 8'd80 && r <= 8'd87) p.col = 5'd8;
    else p.hit = 1'b0;
    return p;
  endfunction
endpackage

// File: rtl/fuse_lock_eval.sv
module fuse_lock_eval
  import fuse_prog_pkg::*;
(
  input  logic              pgm_en,
  input  logic              band_lock,
  input  fuse_addr_t        addr,
  output logic [ROW_W-1:0]  guard_row,
  input  logic [WORD_W-1:0] guard_word,
  output logic              locked
);
  lock_ptr_t               ptr;
  logic                    band_hit;
  logic                    fuse_hit;
  logic [ROW_W+COL_W-1:0]  pos;

  always_comb begin
    ptr       = page0_guard(addr.row);
    pos       = {addr.row, addr.col};
    guard_row = LOCK_ROW;
    band_hit  = 1'b0;
    fuse_hit  = 1'b0;
    if (addr.page == '0) begin
      guard_row = ptr.row;
      band_hit  = band_lock && (addr.row >= BAND_LO) && (addr.row <= BAND_HI);
      fuse_hit  = ptr.hit && guard_word[ptr.col];
    end else if (addr.page == WIN_PAGE) begin
      fuse_hit  = (pos >= WIN_LO) && (pos <= WIN_HI) && guard_word[WIN_LOCK_COL];
    end
    locked = !pgm_en || band_hit || fuse_hit;
  end
endmodule

// File: rtl/fuse_bit_array.sv
module fuse_bit_array
  import fuse_prog_pkg::*;
#(
  parameter int PAGES = 3,
  parameter int ROWS  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  fuse_addr_t        wr_addr,
  output logic              wr_ok,
  input  logic [ROW_W-1:0]  guard_row,
  output logic [WORD_W-1:0] guard_word,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = PAGES * ROWS;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] words [DEPTH];
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_ok;
  logic [WORD_W-1:0] wr_next;

  function automatic logic [IDX_W-1:0] flat(input logic [PAGE_W-1:0] pg,
                                            input logic [ROW_W-1:0] rw);
    int unsigned v;
    v = int'(pg) * ROWS + int'(rw);
    return v[IDX_W-1:0];
  endfunction

  always_comb begin
    wr_ok      = (int'(wr_addr.page) < PAGES) && (int'(wr_addr.row) < ROWS);
    rd_ok      = (int'(rd_page) < PAGES) && (int'(rd_row) < ROWS);
    wr_idx     = flat(wr_addr.page, wr_addr.row);
    rd_idx     = flat(rd_page, rd_row);
    wr_next    = wr_ok ? (words[wr_idx] | (WORD_W'(1) << wr_addr.col)) : '0;
    rd_word    = rd_ok ? words[rd_idx] : '0;
    guard_word = (int'(guard_row) < ROWS) ? words[flat('0, guard_row)] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (wr_en && wr_ok) begin
      words[wr_idx] <= wr_next;
    end
  end

  // R10: the controller never issues a write outside the array
  always_comb begin
    if (rst_n && wr_en) assert_write_in_range_R10: assert (wr_ok);
  end

  // R9: a written bit reads as 1 afterwards
  assert_bit_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ok) |=> words[$past(wr_idx)][$past(wr_addr.col)]);
endmodule

// File: rtl/fuse_prog_ctrl.sv
module fuse_prog_ctrl
  import fuse_prog_pkg::*;
#(
  parameter int PAGES = 3,
  parameter int ROWS  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_en,
  input  logic              soft_lock_set,
  input  logic              err_clr,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PAGE_W-1:0] rd_page,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_word,
  output logic              done_pulse,
  output logic              err_pulse,
  output logic              err_status
);
  fuse_addr_t        addr;
  logic [ROW_W-1:0]  guard_row;
  logic [WORD_W-1:0] guard_word;
  logic              locked;
  logic              in_range;
  logic              grant;
  logic              refuse;

  logic done_q, done_d;
  logic err_q,  err_d;
  logic sts_q,  sts_d;
  logic band_q, band_d;

  assign addr = fuse_addr_t'(req_addr);

  fuse_lock_eval u_eval (
    .pgm_en     (pgm_en),
    .band_lock  (band_q),
    .addr       (addr),
    .guard_row  (guard_row),
    .guard_word (guard_word),
    .locked     (locked)
  );

  fuse_bit_array #(.PAGES(PAGES), .ROWS(ROWS)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (grant),
    .wr_addr    (addr),
    .wr_ok      (in_range),
    .guard_row  (guard_row),
    .guard_word (guard_word),
    .rd_page    (rd_page),
    .rd_row     (rd_row),
    .rd_word    (rd_word)
  );

  always_comb begin
    grant  = req_valid && !locked && in_range;
    refuse = req_valid && !grant;
    done_d = req_valid;
    err_d  = refuse;
    band_d = band_q || soft_lock_set;
    sts_d  = refuse ? 1'b1 : (err_clr ? 1'b0 : sts_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      sts_q  <= 1'b0;
      band_q <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      sts_q  <= sts_d;
      band_q <= band_d;
    end
  end

  assign done_pulse = done_q;
  assign err_pulse  = err_q;
  assign err_status = sts_q;

  assert_done_each_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done_pulse);
  assert_done_only_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done_pulse);
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> done_pulse);
  assert_disabled_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pgm_en) |=> err_pulse);
  assert_band_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && band_q && addr.page == '0 && addr.row >= BAND_LO && addr.row <= BAND_HI)
    |=> err_pulse);
  assert_band_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    band_q |=> band_q);
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_status && !err_clr) |=> err_status);
  assert_err_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> err_status);
endmodule

// File: tb/fuse_prog_ctrl_test.sv
module fuse_prog_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pgm_en, soft_lock_set, err_clr, req_valid;
  logic [16:0] req_addr;
  logic [3:0]  rd_page;
  logic [7:0]  rd_row;
  logic [31:0] rd_word;
  logic        done_pulse, err_pulse, err_status;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  fuse_prog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pgm_en(pgm_en), .soft_lock_set(soft_lock_set),
    .err_clr(err_clr), .req_valid(req_valid), .req_addr(req_addr),
    .rd_page(rd_page), .rd_row(rd_row), .rd_word(rd_word),
    .done_pulse(done_pulse), .err_pulse(err_pulse), .err_status(err_status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic prog(input int pg, input int rw, input int cl, input bit refused, input string req);
    req_valid = 1'b1;
    req_addr  = {pg[3:0], rw[7:0], cl[4:0]};
    exp_q.push_back(refused);
    tag_q.push_back(req);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic peek(input int pg, input int rw, input logic [31:0] exp, input string req);
    rd_page = pg[3:0];
    rd_row  = rw[7:0];
    #1;
    check(req, rd_word, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (done_pulse) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected done", 32'(done_pulse), 32'd0);
        end else begin
          check({tag_q.pop_front(), " err_pulse"}, 32'(err_pulse), 32'(exp_q.pop_front()));
        end
      end else if (err_pulse) begin
        check("R7 err without done", 32'(err_pulse), 32'd0);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pgm_en = 1'b0; soft_lock_set = 1'b0; err_clr = 1'b0;
    req_valid = 1'b0; req_addr = '0; rd_page = '0; rd_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 done", 32'(done_pulse), 0);
    check("R11 err_status", 32'(err_status), 0);
    peek(0, 43, 0, "R11 array");

    // R2 disabled
    prog(1, 5, 3, 1, "R2");
    peek(1, 5, 0, "R2 unchanged");
    check("R8 flag set", 32'(err_status), 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check("R8 flag cleared", 32'(err_status), 0);

    pgm_en = 1'b1;
    // R1 decode and R9 idempotent
    prog(1, 5, 3, 0, "R1");
    peek(1, 5, 32'h8, "R1 bit set");
    prog(1, 5, 3, 0, "R9");
    prog(1, 5, 9, 0, "R9");
    peek(1, 5, 32'h208, "R9 bits kept");
    // R5 rows without guard
    prog(0, 200, 31, 0, "R5");
    prog(0, 36, 0, 0, "R5");

    // R4 guard table, back-to-back lock then use
    prog(0, 12, 0, 0, "R4 pre");
    prog(0, 43, 11, 0, "R4 lockfuse");
    prog(0, 12, 1, 1, "R4 row12");
    prog(0, 19, 0, 1, "R4 row19");
    prog(0, 20, 0, 0, "R4 row20 free");
    peek(0, 12, 32'h1, "R4 row12 unchanged");
    prog(0, 43, 13, 0, "R4 lockfuse");
    prog(0, 27, 5, 1, "R4 row27");
    prog(0, 28, 0, 0, "R4 row28 free");
    prog(0, 43, 15, 0, "R4 lockfuse");
    prog(0, 35, 0, 1, "R4 row35");
    prog(0, 4, 31, 0, "R4 self guard");
    prog(0, 4, 0, 1, "R4 row4");
    prog(0, 4, 31, 1, "R4 row4 again");
    prog(0, 11, 0, 0, "R4 row11 pre");
    prog(0, 43, 27, 0, "R4 lockfuse");
    prog(0, 8, 0, 1, "R4 row8");
    prog(0, 43, 28, 0, "R4 lockfuse");
    prog(0, 37, 0, 1, "R4 row37");
    prog(0, 43, 6, 0, "R4 lockfuse");
    prog(0, 64, 0, 1, "R4 row64");
    prog(0, 71, 0, 1, "R4 row71");
    prog(0, 72, 0, 0, "R4 row72 free");
    prog(0, 43, 7, 0, "R4 lockfuse");
    prog(0, 79, 0, 1, "R4 row79");
    prog(0, 80, 0, 0, "R4 row80 free");
    prog(0, 43, 8, 0, "R4 lockfuse");
    prog(0, 87, 0, 1, "R4 row87");
    prog(0, 88, 0, 0, "R5 row88 free");

    // R6 page-2 window
    prog(2, 129, 0, 0, "R6 pre");
    prog(0, 43, 16, 0, "R6 lockfuse");
    prog(2, 129, 1, 1, "R6 row129");
    prog(2, 255, 27, 1, "R6 row255 col27");
    prog(2, 255, 28, 0, "R6 row255 col28");
    prog(2, 128, 0, 0, "R6 row128");
    prog(1, 200, 0, 0, "R6 page1");
    peek(2, 129, 32'h1, "R6 row129 unchanged");
    peek(2, 255, 32'h1000_0000, "R6 row255");

    // R3 software band
    prog(0, 44, 0, 0, "R3 pre");
    soft_lock_set = 1'b1; @(negedge clk); soft_lock_set = 1'b0;
    prog(0, 44, 1, 1, "R3 row44");
    prog(0, 51, 0, 1, "R3 row51");
    prog(0, 52, 0, 0, "R3 row52");
    prog(0, 43, 20, 0, "R3 row43");
    repeat (3) @(negedge clk);
    prog(0, 48, 0, 1, "R3 still locked");
    peek(0, 44, 32'h1, "R3 row44 unchanged");

    // R10 out of range
    prog(3, 0, 0, 1, "R10 page3");
    prog(15, 0, 0, 1, "R10 page15");
    peek(3, 0, 0, "R10 no change");
    peek(0, 0, 0, "R10 no wrap");

    // R8 set wins over clear
    err_clr = 1'b1;
    prog(3, 1, 1, 1, "R8 set wins");
    err_clr = 1'b0;
    check("R8 set wins flag", 32'(err_status), 1);

    // R11 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 flag after reset", 32'(err_status), 0);
    peek(0, 43, 0, "R11 array cleared");
    prog(0, 44, 2, 0, "R11 band unlocked");
    prog(0, 12, 2, 0, "R11 guard cleared");
    peek(0, 44, 32'h4, "R11 row44");
    repeat (2) @(negedge clk);
    check("R7 scoreboard drained", 32'(exp_q.size()), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule